// File: doc/BRIEF.md
# Interrupt Distributor with Sixteen-Bit Target Fields

This block collects interrupt requests and hands each one to the CPU interfaces it is routed to. Three kinds of source exist. IDs 0 to 15 are raised only by software. IDs 16 to 31 are per-CPU lines. IDs 32 and up are shared peripheral lines. Every source has an enable bit, a pending state, a trigger mode and a list of target CPUs. A pending and enabled source drives the interrupt output of each CPU it targets. A global switch gates all outputs.

Software reaches the block over a single-cycle register bus. The bus carries a byte address, write data, a write strobe and combinational read data, plus the index of the CPU making the access. That index selects the per-CPU copy of the enable and pending state for IDs 0 to 31. For shared sources each target field is 16 bits wide, two to a 32-bit word. Only the low `NCPU` bits of a field are stored. The default configuration has 4 CPUs and 64 sources.

Top module: `irq_distributor`

## Requirements
- R1: A write to the enable-set bank (0x100 + 4·w) sets the enable of source 32·w+b for every 1 in bit b, and a write to the enable-clear bank (0x180 + 4·w) clears it. Zeros in the write data change nothing. Both banks read back the current enables.
- R2: For IDs 0–31, enable and pending are kept separately for each CPU interface. Reads and writes use the copy of the accessing CPU (`bus_cpu`). Shared sources have a single copy.
- R3: The trigger word at 0xC00 + 4·w holds one bit per source (1 = rising edge, 0 = active-high level). Bits for IDs 0–15 always read 1, and writes to them are ignored.
- R4: A level source reads pending exactly while its input is high. An edge source latches pending on a 0→1 transition of its input and stays pending until it is cleared.
- R5: The target field of shared source n is at 0x800 + ((2·n) & ~3). Odd n uses bits 31:16 and even n uses bits 15:0. Bit c selects CPU c, and bits at and above `NCPU` read 0.
- R6: A target word for IDs 0–31 reads the accessing CPU's one-hot mask in both halves. Writes to these words are ignored.
- R7: The type register at 0x004 reads (min(NSRC,510)+31)/32 − 1 in bits 4:0 and 0 elsewhere. The default configuration reads 1.
- R8: A write to 0xF00 with ID in bits 3:0 and CPU map in bits 23:8 makes that ID pending on every CPU c < `NCPU` whose map bit 8+c is 1. Map bits for CPUs that do not exist are ignored.
- R9: While bit 0 of the control register (0x000) is 0, all `irq_out` bits are 0.
- R10: With control bit 0 set, `irq_out[c]` is 1 exactly when CPU c has a pending, enabled private source, or some shared source is pending, enabled and targets c.
- R11: The pending word at 0x200 + 4·w reads the pending state. A write of 1 to bit b at 0x280 + 4·w clears the latched pending of source 32·w+b. Clears of private IDs use the accessing CPU's copy.
- R12: Unmapped addresses, the software-interrupt register and words beyond the implemented sources read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cpu | input | CW | Index of the CPU making the access |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ppi_in | input | NCPU·16 | Per-CPU lines for IDs 16–31, CPU c at bits 16c+15:16c |
| spi_in | input | NSRC−32 | Shared lines, bit j is ID 32+j |
| irq_out | output | NCPU | Interrupt request per CPU interface |

## Verification
Some properties hold on every cycle and are checked by assertions. The global switch gates every output. Enables change only when one of the two enable banks is written. A set-bank write leaves its ones in place. The fixed trigger bits always read as edge. Private target words always read a one-hot mask. A software interrupt to CPU 0 lands in that CPU's pending bits.

Other behaviours need the bench's scenarios. These are the separation between CPU copies, the full sweep of target layout and masking, level and edge behaviour on real input waveforms, and the routing of several sources to several CPUs at once.

// File: rtl/dist_pkg.sv
package dist_pkg;
    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_TYPE = 12'h004;
    localparam logic [11:0] A_SGI  = 12'hF00;
    localparam logic [4:0]  R_ENS  = 5'b00010;   // 0x100
    localparam logic [4:0]  R_ENC  = 5'b00011;   // 0x180
    localparam logic [4:0]  R_PND  = 5'b00100;   // 0x200
    localparam logic [4:0]  R_PCL  = 5'b00101;   // 0x280
    localparam logic [4:0]  R_CFG  = 5'b11000;   // 0xC00
    localparam logic [1:0]  R_TGT  = 2'b10;      // 0x800..0xBFF
endpackage

// File: rtl/dist_trigger.sv
module dist_trigger #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = line_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_o = line_i & ~prev_q;
endmodule

// File: rtl/dist_route.sv
module dist_route #(
    parameter int NCPU = 4,
    parameter int NSPI = 32
) (
    input  logic                       gate_i,
    input  logic [NCPU-1:0][31:0]      en_p_i,
    input  logic [NCPU-1:0][31:0]      act_p_i,
    input  logic [NSPI-1:0]            en_s_i,
    input  logic [NSPI-1:0]            act_s_i,
    input  logic [NSPI-1:0][NCPU-1:0]  tgt_i,
    output logic [NCPU-1:0]            irq_o
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSPI-1:0] col;
        for (genvar j = 0; j < NSPI; j++) begin : g_col
            assign col[j] = tgt_i[j][c];
        end
        assign irq_o[c] = gate_i & ((|(en_p_i[c] & act_p_i[c])) |
                                    (|(en_s_i & act_s_i & col)));
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
    parameter int NCPU = 4,
    parameter int NSRC = 64,
    parameter int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        bus_cpu,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_we,
    output logic [31:0]          bus_rdata,
    input  logic [NCPU*16-1:0]   ppi_in,
    input  logic [NSRC-33:0]     spi_in,
    output logic [NCPU-1:0]      irq_out
);
    import dist_pkg::*;

    localparam int NSPI   = NSRC - 32;
    localparam int NW     = NSRC / 32;
    localparam int NCAP   = (NSRC > 510) ? 510 : NSRC;
    localparam int TYPE_N = (NCAP + 31) / 32 - 1;

    typedef struct packed {
        logic                      ctrl;
        logic [NCPU-1:0][31:0]     en_p;
        logic [NCPU-1:0][31:0]     pd_p;
        logic [NSPI-1:0]           en_s;
        logic [NSPI-1:0]           pd_s;
        logic [NSRC-1:0]           cfg;
        logic [NSPI-1:0][NCPU-1:0] tgt;
    } state_t;

    state_t s_d, s_q;

    logic [NCPU*16-1:0]    rise_p;
    logic [NSPI-1:0]       rise_s;
    logic [NCPU-1:0][31:0] act_p;
    logic [NSPI-1:0]       act_s;

    // address decode
    logic [4:0]  word;
    logic [7:0]  tw;
    logic        is_ens, is_enc, is_pnd, is_pcl, is_cfg, is_tgt, is_sgi;
    logic [15:0] oh_cpu;

    assign word   = bus_addr[6:2];
    assign tw     = bus_addr[9:2];
    assign is_ens = bus_addr[11:7] == R_ENS;
    assign is_enc = bus_addr[11:7] == R_ENC;
    assign is_pnd = bus_addr[11:7] == R_PND;
    assign is_pcl = bus_addr[11:7] == R_PCL;
    assign is_cfg = bus_addr[11:7] == R_CFG;
    assign is_tgt = bus_addr[11:10] == R_TGT;
    assign is_sgi = bus_addr == A_SGI;
    assign oh_cpu = 16'(1) << bus_cpu;

    dist_trigger #(.W(NCPU*16)) u_trig_p (
        .clk(clk), .rst_n(rst_n), .line_i(ppi_in), .rise_o(rise_p));

    dist_trigger #(.W(NSPI)) u_trig_s (
        .clk(clk), .rst_n(rst_n), .line_i(spi_in), .rise_o(rise_s));

    // effective pending: latch for edge sources, live input for level ones
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            act_p[c][15:0] = s_q.pd_p[c][15:0];
            for (int k = 0; k < 16; k++)
                act_p[c][16+k] = s_q.cfg[16+k] ? s_q.pd_p[c][16+k] : ppi_in[c*16+k];
        end
        for (int j = 0; j < NSPI; j++)
            act_s[j] = s_q.cfg[32+j] ? s_q.pd_s[j] : spi_in[j];
    end

    // next state
    always_comb begin
        s_d = s_q;
        if (bus_we) begin
            if (bus_addr == A_CTRL) s_d.ctrl = bus_wdata[0];
            if (is_ens || is_enc || is_pcl || is_cfg) begin
                if (word == 5'd0) begin
                    if (is_ens) s_d.en_p[bus_cpu] = s_q.en_p[bus_cpu] | bus_wdata;
                    if (is_enc) s_d.en_p[bus_cpu] = s_q.en_p[bus_cpu] & ~bus_wdata;
                    if (is_pcl) s_d.pd_p[bus_cpu] = s_q.pd_p[bus_cpu] & ~bus_wdata;
                end
                for (int w = 1; w < NW; w++) begin
                    if (word == 5'(w)) begin
                        if (is_ens) s_d.en_s[(w-1)*32 +: 32] = s_q.en_s[(w-1)*32 +: 32] | bus_wdata;
                        if (is_enc) s_d.en_s[(w-1)*32 +: 32] = s_q.en_s[(w-1)*32 +: 32] & ~bus_wdata;
                        if (is_pcl) s_d.pd_s[(w-1)*32 +: 32] = s_q.pd_s[(w-1)*32 +: 32] & ~bus_wdata;
                    end
                end
                for (int w = 0; w < NW; w++)
                    if (is_cfg && word == 5'(w)) s_d.cfg[w*32 +: 32] = bus_wdata;
            end
            if (is_tgt) begin
                for (int j = 0; j < NSPI; j++)
                    if (tw == 8'(16 + j/2))
                        s_d.tgt[j] = (j % 2 == 1) ? bus_wdata[16 +: NCPU] : bus_wdata[0 +: NCPU];
            end
            if (is_sgi) begin
                for (int c = 0; c < NCPU; c++)
                    if (bus_wdata[8+c]) s_d.pd_p[c][bus_wdata[3:0]] = 1'b1;
            end
        end
        s_d.cfg[15:0] = '1;
        // edge latching wins over a clear in the same cycle; level sources hold no latch
        for (int c = 0; c < NCPU; c++)
            s_d.pd_p[c][31:16] = (s_d.pd_p[c][31:16] | rise_p[c*16 +: 16]) & s_d.cfg[31:16];
        s_d.pd_s = (s_d.pd_s | rise_s) & s_d.cfg[NSRC-1:32];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.cfg[15:0] <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) bus_rdata = {31'b0, s_q.ctrl};
        if (bus_addr == A_TYPE) bus_rdata = {27'b0, 5'(TYPE_N)};
        if (is_ens || is_enc || is_pnd || is_pcl) begin
            if (word == 5'd0) bus_rdata = (is_ens || is_enc) ? s_q.en_p[bus_cpu] : act_p[bus_cpu];
            for (int w = 1; w < NW; w++)
                if (word == 5'(w))
                    bus_rdata = (is_ens || is_enc) ? s_q.en_s[(w-1)*32 +: 32] : act_s[(w-1)*32 +: 32];
        end
        if (is_cfg) begin
            for (int w = 0; w < NW; w++)
                if (word == 5'(w)) bus_rdata = s_q.cfg[w*32 +: 32];
        end
        if (is_tgt) begin
            if (tw < 8'd16) bus_rdata = {oh_cpu, oh_cpu};
            for (int j = 0; j < NSPI; j++)
                if (tw == 8'(16 + j/2)) begin
                    if (j % 2 == 1) bus_rdata[31:16] = 16'(s_q.tgt[j]);
                    else            bus_rdata[15:0]  = 16'(s_q.tgt[j]);
                end
        end
    end

    dist_route #(.NCPU(NCPU), .NSPI(NSPI)) u_route (
        .gate_i(s_q.ctrl), .en_p_i(s_q.en_p), .act_p_i(act_p),
        .en_s_i(s_q.en_s), .act_s_i(act_s), .tgt_i(s_q.tgt), .irq_o(irq_out));

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ctrl |-> irq_out == '0); // R9
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (is_ens || is_enc)) |=> $stable(s_q.en_s) && $stable(s_q.en_p)); // R1
    AST_ENSET_STICK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && is_ens && word == 5'd1) |=> (s_q.en_s[31:0] & $past(bus_wdata)) == $past(bus_wdata)); // R1
    AST_SGI_CFG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cfg && word == 5'd0) |-> bus_rdata[15:0] == 16'hFFFF); // R3
    AST_PRIV_TGT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tgt && tw < 8'd16) |-> $onehot(bus_rdata[15:0]) && bus_rdata[31:16] == bus_rdata[15:0]); // R6
    AST_SGI_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && is_sgi && bus_wdata[8]) |=> s_q.pd_p[0][$past(bus_wdata[3:0])]); // R8
endmodule

// File: tb/sim_irq_distributor.sv
module sim_irq_distributor;
    localparam int NCPU = 4;
    localparam int NSRC = 64;
    localparam int CW   = 2;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [CW-1:0]     bus_cpu = '0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 0;
    logic [31:0]       bus_rdata;
    logic [NCPU*16-1:0] ppi_in = '0;
    logic [NSRC-33:0]  spi_in = '0;
    logic [NCPU-1:0]   irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_distributor #(.NCPU(NCPU), .NSRC(NSRC), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .ppi_in(ppi_in), .spi_in(spi_in), .irq_out(irq_out));

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, int cpu);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cpu = CW'(cpu); bus_we = 1;
        @(posedge clk); #1;
        bus_we = 0;
    endtask

    task automatic rd(logic [11:0] a, int cpu, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_cpu = CW'(cpu);
        #1 d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [31:0] pat(int c);
        return (32'h0F0F_0000 ^ (32'(c) << 20)) | (32'd1 << c);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // reset state
        rd(12'h004, 0, d); chk("R7 type", d, 32'd1);
        rd(12'h000, 0, d); chk("R9 ctrl reset", d, 32'd0);
        chk("R9 irq reset", 32'(irq_out), 32'd0);
        rd(12'hC00, 0, d); chk("R3 cfg reset", d, 32'h0000_FFFF);

        // R1 / R2: banked private enables
        for (int c = 0; c < NCPU; c++) wr(12'h100, pat(c), c);
        for (int c = 0; c < NCPU; c++) begin
            rd(12'h100, c, d); chk("R2 banked enable", d, pat(c));
        end
        for (int c = 0; c < NCPU; c++) wr(12'h180, pat(c) & 32'h00FF_00FF, c);
        for (int c = 0; c < NCPU; c++) begin
            wr(12'h100, 32'd0, c);
            wr(12'h180, 32'd0, c);
            rd(12'h180, c, d); chk("R1 clear and zero writes", d, pat(c) & 32'hFF00_FF00);
        end
        wr(12'h104, 32'hDEAD_BEEF, 0);
        rd(12'h104, 3, d); chk("R1 shared enable set", d, 32'hDEAD_BEEF);
        wr(12'h184, 32'h0000_FFFF, 2);
        rd(12'h104, 1, d); chk("R1 shared enable clear", d, 32'hDEAD_0000);

        // R5: target sweep over shared sources
        for (int t = 16; t < 32; t++) wr(12'h800 + 12'(t*4), 32'(t) * 32'h0005_0003 ^ 32'hFFF0_FFF0, 0);
        for (int t = 16; t < 32; t++) begin
            v = 32'(t) * 32'h0005_0003 ^ 32'hFFF0_FFF0;
            rd(12'h800 + 12'(t*4), 1, d); chk("R5 target layout", d, v & 32'h000F_000F);
        end
        wr(12'h840, 32'h0003_0000, 0);   // source 33 (odd) -> upper half
        rd(12'h840, 0, d); chk("R5 odd source upper half", d, 32'h0003_0000);

        // R6: private target words
        wr(12'h800, 32'hFFFF_FFFF, 0);
        for (int c = 0; c < NCPU; c++)
            for (int t = 0; t < 16; t++) begin
                rd(12'h800 + 12'(t*4), c, d);
                chk("R6 private target", d, {16'(1) << c, 16'(1) << c});
            end

        // R3: fixed trigger of IDs 0-15
        wr(12'hC00, 32'h0, 0);
        rd(12'hC00, 0, d); chk("R3 cfg write zero", d, 32'h0000_FFFF);
        wr(12'hC00, 32'hFFFF_FFFF, 0);
        rd(12'hC00, 0, d); chk("R3 cfg write ones", d, 32'hFFFF_FFFF);
        wr(12'hC00, 32'h0, 0);

        // R4: level shared source 32
        @(negedge clk); spi_in[0] = 1;
        rd(12'h204, 0, d); chk("R4 level high", d, 32'd1);
        @(negedge clk); spi_in[0] = 0;
        rd(12'h204, 0, d); chk("R4 level low", d, 32'd0);
        // R4 / R11: edge
        wr(12'hC04, 32'd1, 0);
        @(negedge clk); spi_in[0] = 1;
        @(negedge clk); spi_in[0] = 0;
        tick();
        rd(12'h204, 0, d); chk("R4 edge latched", d, 32'd1);
        wr(12'h284, 32'd1, 0);
        rd(12'h204, 0, d); chk("R11 pending clear", d, 32'd0);
        // R2: per-CPU level line, cpu1 id16
        @(negedge clk); ppi_in[16] = 1;
        rd(12'h200, 1, d); chk("R2 ppi own cpu", d, 32'h0001_0000);
        rd(12'h200, 0, d); chk("R2 ppi other cpu", d, 32'h0);
        @(negedge clk); ppi_in[16] = 0;

        // R8: software interrupt id 5 to cpus 1 and 3; high map bits ignored
        wr(12'hF00, 32'h00FF_0A05, 0);
        for (int c = 0; c < NCPU; c++) begin
            rd(12'h200, c, d);
            chk("R8 sgi pending", d, (c == 1 || c == 3) ? 32'h20 : 32'h0);
        end

        // R9 / R10: routing
        for (int c = 0; c < NCPU; c++) wr(12'h180, 32'hFFFF_FFFF, c);
        wr(12'h184, 32'hFFFF_FFFF, 0);
        wr(12'h840, 32'h0000_0004, 0);   // source 32 -> cpu2
        wr(12'h104, 32'd1, 0);
        @(negedge clk); spi_in[0] = 1;
        @(negedge clk); spi_in[0] = 0;
        tick();
        chk("R9 gated off", 32'(irq_out), 32'h0);
        wr(12'h000, 32'd1, 0);
        tick();
        chk("R10 shared to cpu2", 32'(irq_out), 32'h4);
        wr(12'h100, 32'h20, 1);
        tick();
        chk("R10 sgi to cpu1", 32'(irq_out), 32'h6);
        wr(12'h284, 32'd1, 0);
        tick();
        chk("R10 after clear", 32'(irq_out), 32'h2);
        wr(12'h000, 32'd0, 0);
        tick();
        chk("R9 disabled again", 32'(irq_out), 32'h0);

        // R12: unmapped reads
        rd(12'hF00, 0, d); chk("R12 sgi reads zero", d, 32'h0);
        rd(12'h300, 0, d); chk("R12 unmapped", d, 32'h0);
        rd(12'h108, 0, d); chk("R12 beyond sources", d, 32'h0);
        rd(12'h880, 0, d); chk("R12 target beyond sources", d, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule